// File: doc/BRIEF.md
# Full-Duplex Asynchronous Serial Transceiver

This block sends and receives character frames on a pair of serial lines. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit (even or odd), and one or two high stop bits. The transmit and receive paths run independently of each other, so both directions can be active at once. Each path keeps a one-byte holding register next to its shift register. Software can therefore queue the next byte, or collect the last one, while a frame is still on the line.

All bit timing is counted in ticks of an oversampling clock that runs at sixteen times the bit rate. A two-bit source select decides where those ticks come from. They can come from an internal tick enable, produced by a rate generator outside this block. They can also come from rising edges of an external clock on the serial-clock pin, which is first synchronised to the core clock. The same select decides whether the pin is left undriven or drives a clock at the bit rate. The receiver locks onto the falling edge of the start bit and captures every bit at the middle of its cell. It reports parity errors, framing errors and overruns together with the received byte.

Top module: `duplex_uart`

## Requirements
- R1: After reset, txd is 1, tx_empty is 1, and rx_full, parity_err, frame_err, overrun and sck_oe are all 0.
- R2: Each bit cell on txd lasts 16 ticks. The order on the line is: a start bit of 0; data bits 0 to 7; then, when par_en=1, a parity bit that gives an even count of ones over data and parity (par_odd=0) or an odd count (par_odd=1); then one stop bit of 1, or two when two_stop=1.
- R3: A pulse on wr_en is taken only while tx_empty=1, and it clears tx_empty on the next edge. Pulses on wr_en while tx_empty=0 have no effect. A queued byte moves into the shifter on the first tick when the line is idle, or on the tick that ends the last stop bit, so back-to-back frames have no idle gap. tx_empty returns to 1 on that same edge.
- R4: The receiver passes rxd through a two-flop synchroniser. It detects a start bit on a tick where the synchronised line is low while it is idle. It samples every later bit on the eighth tick of that bit's cell. When the first stop bit has been sampled, the byte appears on rd_data and rx_full becomes 1.
- R5: If the start bit reads high at its mid-cell sample, the receiver treats it as a glitch. It returns to idle and loads nothing.
- R6: When a byte is loaded, parity_err is set if parity is enabled and the parity bit does not match the selected sense, and frame_err is set if the first stop bit sampled 0. Both flags stay with the byte and clear when it is read.
- R7: If a frame completes while rx_full=1 and rd_en is 0, rd_data is kept unchanged and overrun becomes 1. A read clears overrun.
- R8: A pulse on rd_en clears rx_full. While rx_full=1 and no read occurs, rx_full and rd_data hold their values.
- R9: clk_sel=00 selects tick16_int and leaves sck_oe=0. clk_sel=01 selects tick16_int, sets sck_oe=1, and drives sck_out high for 8 ticks and low for 8 ticks. clk_sel=10 or 11 ignores tick16_int, uses the rising edges of the synchronised sck_in as ticks, and keeps sck_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Tick source and serial-clock pin function |
| tick16_int | input | 1 | Internal enable at 16 times the bit rate |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | Transmit two stop bits |
| wr_en | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read strobe for the receive holding register |
| rd_data | output | 8 | Last received byte |
| tx_empty | output | 1 | Transmit holding register can accept a byte |
| rx_full | output | 1 | Receive holding register holds an unread byte |
| parity_err | output | 1 | Parity mismatch on the held byte |
| frame_err | output | 1 | Low stop bit on the held byte |
| overrun | output | 1 | A frame was lost because the buffer was full |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| sck_in | input | 1 | Serial-clock pin, input side |
| sck_out | output | 1 | Serial-clock pin, output value |
| sck_oe | output | 1 | Serial-clock pin, output enable |

## Verification
The bench runs a behavioural model of the transmit line and compares txd and tx_empty against it on every clock. A design that leaves a one-tick gap between queued frames, or that accepts a write while the holding register is busy, shows up as a mismatch in the exact cycle where it occurs. Received bytes come from loopback and from hand-built frames that carry a wrong parity bit, a low stop bit, or only a short low pulse. A receiver that loads on a glitch, overwrites an unread byte, or drops an error flag would report the wrong byte or flag. The external-clock case measures the start bit at exactly 16 periods of sck_in while tick16_int keeps running, which catches a multiplexer that still uses the internal tick.

// File: rtl/duplex_uart_pkg.sv
package duplex_uart_pkg;

    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int OVS_W  = $clog2(OVS);
    localparam int MID    = OVS / 2 - 1;

    typedef enum logic [1:0] {
        CS_INT_QUIET = 2'b00,
        CS_INT_DRIVE = 2'b01,
        CS_EXT_A     = 2'b10,
        CS_EXT_B     = 2'b11
    } clk_src_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP1,
        PH_STOP2
    } phase_e;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    // Parity bit that gives the requested sense over data plus parity.
    function automatic logic par_bit(input logic [DATA_W-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/uart_tick_sel.sv
module uart_tick_sel
    import duplex_uart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e src,
    input  logic     tick_int,
    input  logic     sck_in,
    output logic     tick,
    output logic     sck_out,
    output logic     sck_oe
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sck_prev_q;
    logic [OVS_W-1:0]       div_q;
    logic                   ext_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q     <= '0;
            sck_prev_q <= 1'b0;
            div_q      <= '0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], sck_in};
            sck_prev_q <= sync_q[SYNC_STAGES-1];
            if (tick) div_q <= div_q + 1'b1;
        end
    end

    assign ext_edge = sync_q[SYNC_STAGES-1] & ~sck_prev_q;
    assign tick     = src[1] ? ext_edge : tick_int;
    assign sck_oe   = (src == CS_INT_DRIVE);
    assign sck_out  = sck_oe & ~div_q[OVS_W-1];
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import duplex_uart_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          txd,
    output logic          tx_empty
);
    localparam int IDX_W = $clog2(DW);

    phase_e           st_q, nxt;
    logic [OVS_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    sh_q, hold_q;
    logic             hold_full_q, par_q;
    logic             bit_end, load, last_bit;

    assign bit_end = tick && (cnt_q == OVS_W'(OVS - 1));

    always_comb begin
        nxt      = st_q;
        load     = 1'b0;
        last_bit = 1'b0;
        if (st_q == PH_IDLE) begin
            if (tick && hold_full_q) begin
                load = 1'b1;
                nxt  = PH_START;
            end
        end else if (bit_end) begin
            case (st_q)
                PH_START:  nxt = PH_DATA;
                PH_DATA:   if (idx_q == IDX_W'(DW - 1)) nxt = cfg.par_en ? PH_PARITY : PH_STOP1;
                PH_PARITY: nxt = PH_STOP1;
                PH_STOP1:  if (cfg.two_stop) nxt = PH_STOP2; else last_bit = 1'b1;
                default:   last_bit = 1'b1;
            endcase
            if (last_bit) begin
                load = hold_full_q;
                nxt  = hold_full_q ? PH_START : PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= PH_IDLE;
            cnt_q       <= '0;
            idx_q       <= '0;
            sh_q        <= '0;
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            par_q       <= 1'b0;
        end else begin
            st_q <= nxt;
            if (load) begin
                sh_q  <= hold_q;
                par_q <= par_bit(hold_q, cfg.par_odd);
                cnt_q <= '0;
                idx_q <= '0;
            end else if (tick && st_q != PH_IDLE) begin
                cnt_q <= cnt_q + 1'b1;
                if (bit_end && st_q == PH_DATA) begin
                    sh_q  <= sh_q >> 1;
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (load) begin
                hold_full_q <= 1'b0;
            end else if (wr_en && !hold_full_q) begin
                hold_q      <= wr_data;
                hold_full_q <= 1'b1;
            end
        end
    end

    always_comb begin
        case (st_q)
            PH_START:  txd = 1'b0;
            PH_DATA:   txd = sh_q[0];
            PH_PARITY: txd = par_q;
            default:   txd = 1'b1;
        endcase
    end

    assign tx_empty = ~hold_full_q;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import duplex_uart_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  frame_cfg_t    cfg,
    input  logic          rxd,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rx_full,
    output logic          parity_err,
    output logic          frame_err,
    output logic          overrun
);
    localparam int IDX_W = $clog2(DW);

    logic [1:0]       rs_q;
    logic             rx_s, samp, par_fail;
    phase_e           st_q;
    logic [OVS_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [DW-1:0]    sh_q, buf_q;
    logic             pbit_q, full_q, pe_q, fe_q, ov_q;

    assign rx_s     = rs_q[1];
    assign samp     = tick && (cnt_q == OVS_W'(MID));
    assign par_fail = cfg.par_en && (((^sh_q) ^ pbit_q) != cfg.par_odd);

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q   <= 2'b11;
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            idx_q  <= '0;
            sh_q   <= '0;
            buf_q  <= '0;
            pbit_q <= 1'b0;
            full_q <= 1'b0;
            pe_q   <= 1'b0;
            fe_q   <= 1'b0;
            ov_q   <= 1'b0;
        end else begin
            rs_q <= {rs_q[0], rxd};
            if (rd_en) begin
                full_q <= 1'b0;
                pe_q   <= 1'b0;
                fe_q   <= 1'b0;
                ov_q   <= 1'b0;
            end
            if (st_q == PH_IDLE) begin
                if (tick && !rx_s) begin
                    st_q  <= PH_START;
                    cnt_q <= '0;
                end
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
                if (samp) begin
                    case (st_q)
                        PH_START: begin
                            if (rx_s) st_q <= PH_IDLE;
                            else begin
                                st_q  <= PH_DATA;
                                idx_q <= '0;
                            end
                        end
                        PH_DATA: begin
                            sh_q  <= {rx_s, sh_q[DW-1:1]};
                            idx_q <= idx_q + 1'b1;
                            if (idx_q == IDX_W'(DW - 1))
                                st_q <= cfg.par_en ? PH_PARITY : PH_STOP1;
                        end
                        PH_PARITY: begin
                            pbit_q <= rx_s;
                            st_q   <= PH_STOP1;
                        end
                        default: begin
                            st_q <= PH_IDLE;
                            if (full_q && !rd_en) begin
                                ov_q <= 1'b1;
                            end else begin
                                buf_q  <= sh_q;
                                full_q <= 1'b1;
                                pe_q   <= par_fail;
                                fe_q   <= ~rx_s;
                            end
                        end
                    endcase
                end
            end
        end
    end

    assign rd_data    = buf_q;
    assign rx_full    = full_q;
    assign parity_err = pe_q;
    assign frame_err  = fe_q;
    assign overrun    = ov_q;
endmodule

// File: rtl/duplex_uart.sv
module duplex_uart
    import duplex_uart_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    clk_sel,
    input  logic          tick16_int,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          two_stop,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          tx_empty,
    output logic          rx_full,
    output logic          parity_err,
    output logic          frame_err,
    output logic          overrun,
    output logic          txd,
    input  logic          rxd,
    input  logic          sck_in,
    output logic          sck_out,
    output logic          sck_oe
);
    frame_cfg_t cfg;
    logic       tick;

    assign cfg = '{par_en: par_en, par_odd: par_odd, two_stop: two_stop};

    uart_tick_sel #(.SYNC_STAGES(2)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .src      (clk_src_e'(clk_sel)),
        .tick_int (tick16_int),
        .sck_in   (sck_in),
        .tick     (tick),
        .sck_out  (sck_out),
        .sck_oe   (sck_oe)
    );

    uart_tx #(.DW(DW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .cfg      (cfg),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .txd      (txd),
        .tx_empty (tx_empty)
    );

    uart_rx #(.DW(DW)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .cfg        (cfg),
        .rxd        (rxd),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .rx_full    (rx_full),
        .parity_err (parity_err),
        .frame_err  (frame_err),
        .overrun    (overrun)
    );
endmodule

// File: rtl/duplex_uart_checker.sv
module duplex_uart_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    clk_sel,
    input logic          wr_en,
    input logic          rd_en,
    input logic          txd,
    input logic          tx_empty,
    input logic          rx_full,
    input logic          parity_err,
    input logic          frame_err,
    input logic [DW-1:0] rd_data,
    input logic          sck_oe
);
    a_r3_write_takes: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && wr_en) |=> !tx_empty);

    a_r2_load_starts_low: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty) |-> !txd);

    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_en) |=> rx_full);

    a_r7_data_kept: assert property (@(posedge clk) disable iff (rst)
        (rx_full && !rd_en) |=> $stable(rd_data));

    a_r6_err_with_byte: assert property (@(posedge clk) disable iff (rst)
        (parity_err || frame_err) |-> rx_full);

    a_r9_ext_no_drive: assert property (@(posedge clk) disable iff (rst)
        clk_sel[1] |-> !sck_oe);
endmodule

bind duplex_uart duplex_uart_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_sel    (clk_sel),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .txd        (txd),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .rd_data    (rd_data),
    .sck_oe     (sck_oe)
);

// File: tb/duplex_uart_test.sv
module duplex_uart_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] clk_sel = 2'b00;
    logic       tick16_int;
    logic       par_en = 0, par_odd = 0, two_stop = 0;
    logic       wr_en = 0, rd_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tx_empty, rx_full, parity_err, frame_err, overrun;
    logic       txd, rxd, sck_out, sck_oe;
    logic       sck_in = 1'b0;
    logic       loop = 1'b0, rx_drive = 1'b1;
    logic       sck_run = 1'b0, model_on = 1'b1;
    logic [1:0] tdiv = 2'd0;
    int         scnt = 0;
    int         checks = 0, fails = 0;

    always #4 clk = ~clk;

    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16_int = (tdiv == 2'd3);
    assign rxd = loop ? txd : rx_drive;

    always @(negedge clk) if (sck_run) begin
        scnt = scnt + 1;
        if (scnt == 3) begin scnt = 0; sck_in = ~sck_in; end
    end

    duplex_uart uut (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .tick16_int(tick16_int),
        .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .parity_err(parity_err),
        .frame_err(frame_err), .overrun(overrun), .txd(txd), .rxd(rxd),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural transmit model: a queue of line levels, each held 16 ticks.
    bit         m_act = 0, m_full = 0, m_line = 1, m_was_full, m_ld;
    int         m_left = 0;
    logic [7:0] m_hold = 0;
    bit         m_bits[$];

    always @(posedge clk) begin
        if (rst) begin
            m_act = 0; m_full = 0; m_line = 1; m_left = 0; m_bits.delete();
        end else begin
            m_was_full = m_full;
            m_ld = 0;
            if (tick16_int && m_act) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_bits.size() > 0) begin m_line = m_bits.pop_front(); m_left = 16; end
                    else begin m_act = 0; m_line = 1; end
                end
            end
            if (tick16_int && !m_act && m_was_full) begin
                for (int i = 0; i < 8; i++) m_bits.push_back(m_hold[i]);
                if (par_en) m_bits.push_back((^m_hold) ^ par_odd);
                m_bits.push_back(1'b1);
                if (two_stop) m_bits.push_back(1'b1);
                m_line = 0; m_left = 16; m_act = 1; m_ld = 1;
            end
            if (m_ld) m_full = 0;
            if (wr_en && !m_was_full) begin m_hold = wr_data; m_full = 1; end
        end
    end

    always @(negedge clk) if (!rst && model_on) begin
        chk(txd == m_line, "R2 txd vs model", txd, m_line);
        chk(tx_empty == !m_full, "R3 tx_empty vs model", tx_empty, !m_full);
    end

    task automatic write_byte(input logic [7:0] b);
        while (!tx_empty) @(negedge clk);
        wr_en = 1; wr_data = b;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic expect_rx(input logic [7:0] b, input bit pe, input bit fe, input string req);
        while (!rx_full) @(negedge clk);
        chk(rd_data == b, req, rd_data, b);
        chk(parity_err == pe, "R6 parity_err", parity_err, pe);
        chk(frame_err == fe, "R6 frame_err", frame_err, fe);
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
        @(negedge clk);
        chk(rx_full == 0, "R8 read clears rx_full", rx_full, 0);
        chk(parity_err == 0 && frame_err == 0, "R6 flags clear on read", parity_err | frame_err, 0);
    endtask

    task automatic drive_frame(input logic [7:0] d, input bit pe, input logic pb,
                               input logic stopv, input int stop_cyc);
        rx_drive = 0; repeat (64) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rx_drive = d[i]; repeat (64) @(negedge clk); end
        if (pe) begin rx_drive = pb; repeat (64) @(negedge clk); end
        rx_drive = stopv; repeat (stop_cyc) @(negedge clk);
        rx_drive = 1; repeat (64) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int cyc;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1 && tx_empty == 1, "R1 tx idle", {txd, tx_empty}, 3);
        chk({rx_full, parity_err, frame_err, overrun} == 0, "R1 rx flags", {rx_full, parity_err, frame_err, overrun}, 0);
        chk(sck_oe == 0, "R1 sck_oe", sck_oe, 0);

        // R4 loopback 8N1, R2 checked by model
        loop = 1;
        write_byte(8'hA5); expect_rx(8'hA5, 0, 0, "R4 rx 8N1 A5");
        write_byte(8'h3C); expect_rx(8'h3C, 0, 0, "R4 rx 8N1 3C");
        repeat (200) @(negedge clk);

        // R2 even parity, then odd parity with two stops
        par_en = 1; par_odd = 0;
        write_byte(8'h07); expect_rx(8'h07, 0, 0, "R2 even parity frame");
        repeat (200) @(negedge clk);
        par_odd = 1; two_stop = 1;
        write_byte(8'h81); expect_rx(8'h81, 0, 0, "R2 odd parity two stop");
        repeat (200) @(negedge clk);
        par_en = 0; par_odd = 0; two_stop = 0;

        // R3 back-to-back, write while busy ignored
        write_byte(8'h11);
        write_byte(8'h22);
        wr_en = 1; wr_data = 8'h33;
        @(negedge clk);
        wr_en = 0;
        chk(tx_empty == 0, "R3 busy write ignored", tx_empty, 0);
        expect_rx(8'h11, 0, 0, "R3 first queued byte");
        expect_rx(8'h22, 0, 0, "R3 second queued byte");
        repeat (1500) @(negedge clk);
        chk(rx_full == 0, "R3 no third frame", rx_full, 0);

        // R7 overrun
        write_byte(8'h5A);
        write_byte(8'hC3);
        repeat (1800) @(negedge clk);
        chk(rx_full == 1 && overrun == 1, "R7 overrun set", {rx_full, overrun}, 3);
        chk(rd_data == 8'h5A, "R7 first byte kept", rd_data, 8'h5A);
        rd_en = 1; @(negedge clk); rd_en = 0; @(negedge clk);
        chk(overrun == 0 && rx_full == 0, "R7 read clears overrun", {rx_full, overrun}, 0);

        // R6 parity error, hand-built frame
        loop = 0; rx_drive = 1;
        par_en = 1; par_odd = 0;
        repeat (100) @(negedge clk);
        drive_frame(8'h01, 1, 1'b0, 1'b1, 64);
        expect_rx(8'h01, 1, 0, "R6 parity error byte");
        par_en = 0;

        // R6 framing error
        drive_frame(8'hF0, 0, 1'b0, 1'b0, 36);
        expect_rx(8'hF0, 0, 1, "R6 framing error byte");
        repeat (200) @(negedge clk);
        chk(rx_full == 0, "R5 no spurious load after low stop", rx_full, 0);

        // R5 glitch
        rx_drive = 0; repeat (12) @(negedge clk); rx_drive = 1;
        repeat (200) @(negedge clk);
        chk(rx_full == 0, "R5 glitch ignored", rx_full, 0);
        drive_frame(8'h96, 0, 1'b0, 1'b1, 64);
        expect_rx(8'h96, 0, 0, "R5 frame after glitch");

        // R9 bit-rate clock output
        clk_sel = 2'b01;
        @(negedge clk);
        chk(sck_oe == 1, "R9 sck_oe in mode 01", sck_oe, 1);
        while (sck_out) @(negedge clk);
        while (!sck_out) @(negedge clk);
        cyc = 0;
        while (sck_out) begin cyc++; @(negedge clk); end
        chk(cyc == 32, "R9 sck_out high 8 ticks", cyc, 32);
        while (!sck_out) begin cyc++; @(negedge clk); end
        chk(cyc == 64, "R9 sck_out period 16 ticks", cyc, 64);
        clk_sel = 2'b00;
        @(negedge clk);
        chk(sck_oe == 0 && sck_out == 0, "R9 pin quiet in mode 00", {sck_oe, sck_out}, 0);

        // R9 external clock, tick16_int ignored
        repeat (200) @(negedge clk);
        model_on = 0;
        sck_run = 1;
        clk_sel = 2'b10;
        loop = 1;
        repeat (50) @(negedge clk);
        write_byte(8'hE7);
        while (txd) @(negedge clk);
        cyc = 0;
        while (!txd) begin cyc++; @(negedge clk); end
        chk(cyc == 96, "R9 start bit = 16 external periods", cyc, 96);
        chk(sck_oe == 0, "R9 sck_oe off in external mode", sck_oe, 0);
        expect_rx(8'hE7, 0, 0, "R9 external clock loopback");

        finish_run();
    end
endmodule